// File: doc/BRIEF.md
# Feedback-Divider Slide Controller

This block changes the feedback divider of a PLL that keeps running. The PLL is not stopped and relocked. The block runs a fixed handshake with the PLL's internal ramp logic. It first enters slowdown mode and waits. It then writes the new divider value into the coefficient register and waits again. Next it arms the dynamic ramp and waits, for a bounded time, for the ramp to report completion. When that wait ends, it leaves slowdown and ramp mode in the same cycle.

All waits are counted in pulses of a one-microsecond tick input, so the block works at any system clock rate. The ramp-complete status arrives asynchronously and is resynchronised before use. The block also drives the two ramp step constants that the PLL needs, chosen from a code that selects the reference clock rate. A rate the table does not know raises a configuration error flag.

Top module: `ndiv_slide_ctrl`

## Requirements
- R1: A request whose new divider equals `cur_ndiv` pulses `done_o` one cycle after acceptance and clears `timeout_o`. It raises neither `slowdown_o`, `coeff_wr_o`, `ramp_en_o` nor `busy_o`.
- R2: An accepted request with a different divider follows this sequence. `slowdown_o` rises. After GAP_US tick pulses, `coeff_wr_o` is high for one cycle with `coeff_ndiv_o` holding the requested value. After GAP_US further tick pulses, `ramp_en_o` rises while `slowdown_o` stays high.
- R3: With `ramp_en_o` high, the block waits for the synchronised ramp-done status. If TIMEOUT_US tick pulses pass without it, the block finishes with `timeout_o` set to 1.
- R4: When the ramp wait ends, by success or by timeout, `slowdown_o` and `ramp_en_o` fall on the same clock edge, and `done_o` pulses on that edge.
- R5: Step constants `{step_a_o, step_b_o}` depend on `ref_sel`. Codes 0, 1 and 2 (12, 12.8 and 13 MHz) give 0x2B, 0x0B. Code 3 (19.2 MHz) gives 0x12, 0x08. Code 4 (38.4 MHz) gives 0x04, 0x05.
- R6: `ref_sel` codes 5 to 7 drive `cfg_err_o` to 1 and both step constants to 0. Valid codes drive `cfg_err_o` to 0.
- R7: `req_valid` is ignored while `busy_o` is high. A request made during a slide neither writes the coefficient nor changes `coeff_ndiv_o`.
- R8: `timeout_o` clears on the edge that accepts the next request, and holds its value until then.
- R9: The ramp-done input passes through two flip-flops. After it rises during a ramp wait, `ramp_en_o` falls on the third rising clock edge.
- R10: After reset, `slowdown_o`, `ramp_en_o`, `coeff_wr_o`, `busy_o`, `done_o` and `timeout_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request to slide to `req_ndiv` |
| req_ndiv | input | NDIV_W | Target feedback divider |
| cur_ndiv | input | NDIV_W | Divider currently in the coefficient register |
| ramp_done_async | input | 1 | Ramp-complete status from the PLL, asynchronous |
| us_tick | input | 1 | One-cycle pulse every microsecond |
| ref_sel | input | 3 | Reference clock rate code |
| slowdown_o | output | 1 | Slowdown mode enable |
| ramp_en_o | output | 1 | Dynamic ramp enable |
| coeff_wr_o | output | 1 | Coefficient write strobe |
| coeff_ndiv_o | output | NDIV_W | Divider value to write |
| step_a_o | output | 8 | Ramp step constant A |
| step_b_o | output | 8 | Ramp step constant B |
| cfg_err_o | output | 1 | Unknown reference rate code |
| busy_o | output | 1 | Slide in progress |
| done_o | output | 1 | One-cycle completion pulse |
| timeout_o | output | 1 | Last slide ended without ramp-done |

## Verification
The slide is tried with several input patterns:
- A request equal to the current divider, which separates the no-op path from the full handshake.
- Ramps that answer at once and ramps that answer late. These pin down the two-flop latency and show that success ends the wait early.
- A ramp that never answers, which checks the exact 500-tick bound and the timeout flag. The request that follows shows that the flag clears.
- A second request injected mid-slide, which tells a correctly ignored request from one that overwrites the divider.
- A sweep of all eight rate codes, which exercises every row of the step table and every invalid code.

// File: rtl/slide_pkg.sv
package slide_pkg;

    typedef enum logic [2:0] {
        SL_IDLE   = 3'd0,
        SL_SETTLE = 3'd1,
        SL_LOAD   = 3'd2,
        SL_ARM    = 3'd3,
        SL_RAMP   = 3'd4
    } slide_state_e;

    typedef struct packed {
        logic [7:0] a;
        logic [7:0] b;
        logic       bad;
    } step_cfg_t;

    function automatic step_cfg_t step_lookup(input logic [2:0] sel);
        step_cfg_t r;
        r = '{a: 8'h00, b: 8'h00, bad: 1'b1};
        case (sel)
            3'd0, 3'd1, 3'd2: r = '{a: 8'h2B, b: 8'h0B, bad: 1'b0};
            3'd3:             r = '{a: 8'h12, b: 8'h08, bad: 1'b0};
            3'd4:             r = '{a: 8'h04, b: 8'h05, bad: 1'b0};
            default:          r = '{a: 8'h00, b: 8'h00, bad: 1'b1};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/slide_sync.sv
module slide_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/slide_tick_timer.sv
module slide_tick_timer #(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst || clr)               cnt <= '0;
        else if (tick && cnt != '1)   cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/slide_step_table.sv
module slide_step_table
    import slide_pkg::*;
(
    input  logic [2:0] ref_sel,
    output logic [7:0] step_a,
    output logic [7:0] step_b,
    output logic       bad
);
    step_cfg_t cfg;
    assign cfg    = step_lookup(ref_sel);
    assign step_a = cfg.a;
    assign step_b = cfg.b;
    assign bad    = cfg.bad;
endmodule

// File: rtl/ndiv_slide_ctrl.sv
module ndiv_slide_ctrl
    import slide_pkg::*;
#(
    parameter int NDIV_W     = 8,
    parameter int GAP_US     = 1,
    parameter int TIMEOUT_US = 500,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [NDIV_W-1:0] req_ndiv,
    input  logic [NDIV_W-1:0] cur_ndiv,
    input  logic              ramp_done_async,
    input  logic              us_tick,
    input  logic [2:0]        ref_sel,
    output logic              slowdown_o,
    output logic              ramp_en_o,
    output logic              coeff_wr_o,
    output logic [NDIV_W-1:0] coeff_ndiv_o,
    output logic [7:0]        step_a_o,
    output logic [7:0]        step_b_o,
    output logic              cfg_err_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              timeout_o
);
    localparam int LIMIT_MAX = (TIMEOUT_US > GAP_US) ? TIMEOUT_US : GAP_US;
    localparam int CNT_W     = $clog2(LIMIT_MAX + 2);
    localparam logic [CNT_W-1:0] GAP_CNT = CNT_W'(GAP_US);
    localparam logic [CNT_W-1:0] TMO_CNT = CNT_W'(TIMEOUT_US);

    slide_state_e      state_q, state_d;
    logic [CNT_W-1:0]  us_cnt;
    logic              timer_clr;
    logic              ramp_done_s;
    logic              accept, same_n, ramp_ok, ramp_tmo;
    logic [NDIV_W-1:0] ndiv_q;
    logic              done_q, tmo_q;

    slide_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk), .rst (rst), .d (ramp_done_async), .q (ramp_done_s)
    );

    slide_tick_timer #(.CNT_W(CNT_W)) u_timer (
        .clk (clk), .rst (rst), .clr (timer_clr), .tick (us_tick), .cnt (us_cnt)
    );

    slide_step_table u_steps (
        .ref_sel (ref_sel), .step_a (step_a_o), .step_b (step_b_o), .bad (cfg_err_o)
    );

    assign accept   = (state_q == SL_IDLE) && req_valid;
    assign same_n   = (req_ndiv == cur_ndiv);
    assign ramp_ok  = (state_q == SL_RAMP) && ramp_done_s;
    assign ramp_tmo = (state_q == SL_RAMP) && !ramp_done_s && (us_cnt == TMO_CNT);

    always_comb begin
        state_d = state_q;
        case (state_q)
            SL_IDLE:   if (accept && !same_n)    state_d = SL_SETTLE;
            SL_SETTLE: if (us_cnt == GAP_CNT)    state_d = SL_LOAD;
            SL_LOAD:                             state_d = SL_ARM;
            SL_ARM:    if (us_cnt == GAP_CNT)    state_d = SL_RAMP;
            SL_RAMP:   if (ramp_ok || ramp_tmo)  state_d = SL_IDLE;
            default:                             state_d = SL_IDLE;
        endcase
    end

    assign timer_clr = (state_d != state_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SL_IDLE;
            ndiv_q  <= '0;
            done_q  <= 1'b0;
            tmo_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= (accept && same_n) || ramp_ok || ramp_tmo;
            if (accept && !same_n) ndiv_q <= req_ndiv;
            if (accept)            tmo_q  <= 1'b0;
            else if (ramp_tmo)     tmo_q  <= 1'b1;
        end
    end

    assign slowdown_o   = (state_q != SL_IDLE);
    assign busy_o       = (state_q != SL_IDLE);
    assign ramp_en_o    = (state_q == SL_RAMP);
    assign coeff_wr_o   = (state_q == SL_LOAD);
    assign coeff_ndiv_o = ndiv_q;
    assign done_o       = done_q;
    assign timeout_o    = tmo_q;

    assert_same_n_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        (accept && same_n) |=> (!slowdown_o && done_o && !timeout_o));

    assert_ramp_inside_slow_R2: assert property (@(posedge clk) disable iff (rst)
        ramp_en_o |-> slowdown_o);

    assert_write_before_ramp_R2: assert property (@(posedge clk) disable iff (rst)
        coeff_wr_o |-> (slowdown_o && !ramp_en_o));

    assert_wait_bounded_R3: assert property (@(posedge clk) disable iff (rst)
        ramp_en_o |-> (us_cnt <= TMO_CNT));

    assert_drop_together_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(slowdown_o) |-> ($past(ramp_en_o) && done_o));

    assert_busy_ignores_R7: assert property (@(posedge clk) disable iff (rst)
        busy_o |=> $stable(coeff_ndiv_o));

    assert_timeout_with_done_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(timeout_o) |-> done_o);
endmodule

// File: tb/test_ndiv_slide_ctrl.sv
module test_ndiv_slide_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = CLK_PERIOD / 4;
    localparam int NW         = 8;
    localparam int GAP        = 1;
    localparam int TMO        = 500;

    typedef struct {
        logic        tmo;
        int          writes;
        logic [NW-1:0] ndiv;
    } exp_t;

    logic clk = 1'b0, rst = 1'b1;
    logic req_valid = 1'b0;
    logic [NW-1:0] req_ndiv = '0, cur_ndiv = 8'd40;
    logic ramp_done_async = 1'b0, us_tick = 1'b0;
    logic [2:0] ref_sel = 3'd0;
    logic slowdown_o, ramp_en_o, coeff_wr_o, cfg_err_o, busy_o, done_o, timeout_o;
    logic [NW-1:0] coeff_ndiv_o;
    logic [7:0] step_a_o, step_b_o;

    int checks = 0, failures = 0;
    int cyc = 0;
    int resp_delay = -1;
    int writes_seen = 0;
    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    ndiv_slide_ctrl #(.NDIV_W(NW), .GAP_US(GAP), .TIMEOUT_US(TMO)) i_ndiv_slide_ctrl (
        .clk, .rst, .req_valid, .req_ndiv, .cur_ndiv, .ramp_done_async, .us_tick,
        .ref_sel, .slowdown_o, .ramp_en_o, .coeff_wr_o, .coeff_ndiv_o,
        .step_a_o, .step_b_o, .cfg_err_o, .busy_o, .done_o, .timeout_o
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // microsecond tick: one cycle high every four, changed off the edges
    initial begin
        forever begin
            repeat (3) @(negedge clk);
            #Q us_tick = 1'b1;
            @(negedge clk);
            #Q us_tick = 1'b0;
        end
    end

    // monitor, scoreboard consumer and ramp model
    initial begin
        logic prev_slow = 1'b0, prev_ramp = 1'b0;
        int   tcnt = 0, countdown = -1, drive_cyc = -1;
        exp_t e;
        forever begin
            @(negedge clk);
            if (!rst) begin
                if (slowdown_o && !prev_slow) tcnt = 0;
                else if (slowdown_o && us_tick) tcnt++;
                if (coeff_wr_o) begin
                    check(tcnt == GAP, "R2 ticks before write", tcnt, GAP);
                    check(sb.size() > 0 && coeff_ndiv_o == sb[0].ndiv, "R2/R7 written divider",
                          coeff_ndiv_o, sb.size() > 0 ? sb[0].ndiv : 0);
                    writes_seen++;
                    cur_ndiv <= coeff_ndiv_o;
                    tcnt = 0;
                end
                if (ramp_en_o && !prev_ramp) begin
                    check(tcnt == GAP && slowdown_o, "R2 ticks before ramp enable", tcnt, GAP);
                    tcnt = 0;
                    countdown = resp_delay;
                end
                if (ramp_en_o && countdown == 0) begin
                    ramp_done_async <= 1'b1;
                    drive_cyc = cyc;
                    countdown = -1;
                end else if (ramp_en_o && countdown > 0) begin
                    countdown--;
                end
                if (!ramp_en_o && prev_ramp) begin
                    check(!slowdown_o, "R4 slowdown drops with ramp enable", slowdown_o, 0);
                    check(done_o, "R4 done on ramp exit", done_o, 1);
                    if (drive_cyc >= 0)
                        check(cyc - drive_cyc == 3, "R9 sync latency", cyc - drive_cyc, 3);
                    else
                        check(tcnt == TMO, "R3 timeout window", tcnt, TMO);
                    ramp_done_async <= 1'b0;
                    drive_cyc = -1;
                end
                if (done_o) begin
                    if (sb.size() == 0) begin
                        check(1'b0, "R1 unexpected done", 1, 0);
                    end else begin
                        e = sb.pop_front();
                        check(timeout_o == e.tmo, "R3/R8 timeout flag", timeout_o, e.tmo);
                        check(writes_seen == e.writes, "R1/R7 coefficient writes", writes_seen, e.writes);
                        if (e.writes == 0)
                            check(!slowdown_o && !busy_o, "R1 no slowdown for equal divider", slowdown_o, 0);
                    end
                    writes_seen = 0;
                end
                prev_slow = slowdown_o;
                prev_ramp = ramp_en_o;
            end
        end
    end

    task automatic issue(input logic [NW-1:0] n, input int delay, input bit push);
        exp_t e;
        if (push) begin
            while (busy_o) @(negedge clk);
            e.writes = (n != cur_ndiv) ? 1 : 0;
            e.tmo    = (n != cur_ndiv) && (delay < 0);
            e.ndiv   = n;
            sb.push_back(e);
            resp_delay = delay;
        end
        #Q;
        req_ndiv  = n;
        req_valid = 1'b1;
        @(negedge clk);
        #Q req_valid = 1'b0;
    endtask

    task automatic wait_drain();
        while (sb.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        #Q rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        check({slowdown_o, ramp_en_o, coeff_wr_o, busy_o, done_o, timeout_o} == 6'b0,
              "R10 reset outputs", {slowdown_o, ramp_en_o, coeff_wr_o, busy_o, done_o, timeout_o}, 0);

        // R5 / R6 step table sweep
        for (int s = 0; s < 8; s++) begin
            logic [16:0] exp_v;
            ref_sel = 3'(s);
            #1;
            case (s)
                0, 1, 2: exp_v = {8'h2B, 8'h0B, 1'b0};
                3:       exp_v = {8'h12, 8'h08, 1'b0};
                4:       exp_v = {8'h04, 8'h05, 1'b0};
                default: exp_v = {8'h00, 8'h00, 1'b1};
            endcase
            check({step_a_o, step_b_o, cfg_err_o} == exp_v, s < 5 ? "R5 step constants" : "R6 bad rate code",
                  {step_a_o, step_b_o, cfg_err_o}, exp_v);
        end
        ref_sel = 3'd3;

        // R1 equal divider
        issue(8'd40, 0, 1'b1);
        wait_drain();
        // R2/R4/R9 immediate ramp answer
        issue(8'd52, 0, 1'b1);
        wait_drain();
        // late ramp answer
        issue(8'd33, 37, 1'b1);
        wait_drain();
        // R3 never answers
        issue(8'd90, -1, 1'b1);
        wait_drain();
        check(timeout_o == 1'b1, "R8 timeout holds while idle", timeout_o, 1);
        // R8 flag clears on next request (equal divider)
        issue(8'd90, 0, 1'b1);
        wait_drain();
        // R7 request during a slide is ignored
        issue(8'd17, 5, 1'b1);
        repeat (2) @(negedge clk);
        issue(8'd200, 0, 1'b0);
        wait_drain();
        check(cur_ndiv == 8'd17, "R7 divider after ignored request", cur_ndiv, 17);
        check(coeff_ndiv_o == 8'd17, "R7 coeff output held", coeff_ndiv_o, 17);
        repeat (5) @(negedge clk);
        finish_run();
    end
endmodule